// File: doc/BRIEF.md
# Panel Column Line Double Buffer

This block holds one display line of subfield bit data for a colour plasma panel and streams it to the column data driver chips. Each line carries one bit per colour for every column. The three colour bits of a column arrive together as one pixel word, and the columns arrive in ascending order. The columns are split into contiguous ranges, one range per driver module. All modules are loaded at the same time over parallel serial lanes, so a line takes only as many shift steps as the widest module needs.

There are two line banks. The frame memory side fills one bank while the other bank is being shifted out. A shifted line is committed to the driver outputs by a one-cycle latch strobe. The strobe also hands the emptied bank back to the fill side. Blanking stays asserted whenever no complete line is being shifted.

The fill controller has two states. In `WR_IDLE` an accepted line request moves it to `WR_FILL`. In `WR_FILL` it stays while pixels arrive, and it returns to `WR_IDLE` on the last column of the line. The shift sequencer has four states:
- `RD_IDLE`: waits here. It moves to `RD_SETUP` once its bank holds a complete line.
- `RD_SETUP`: presents the lane bits with the shift clock low, then always moves to `RD_CLOCK`.
- `RD_CLOCK`: raises the shift clock. It returns to `RD_SETUP` for the next bit, or moves to `RD_STROBE` after the final bit.
- `RD_STROBE`: pulses the latch. It moves straight to `RD_SETUP` if the other bank is already full, and otherwise to `RD_IDLE`.

Top module: `pdl_line_pingpong`

## Requirements
- R1: After reset, both blanking outputs are high, all four shift clocks and both strobes are low, and `stall` is low.
- R2: Define MC = ceil(COLS/MODULES). Module lane k at shift step s (s counted from 0 after a strobe or idle) carries column k*MC + s/3, and colour s%3, where colour 0 is `px_rgb[0]`, 1 is `px_rgb[1]` and 2 is `px_rgb[2]`. When that column index is COLS or more, the lane carries 0.
- R3: An accepted line takes exactly COLS cycles with `px_valid` high, and these write columns 0 to COLS-1 in order. A `px_valid` cycle while no line is being filled changes no stored data.
- R4: Each line uses exactly 3*MC shift-clock pulses. Each pulse is high for one cycle and follows a cycle in which the clock is low.
- R5: The strobe is high for exactly one cycle, in the cycle right after the last shift-clock high of a line.
- R6: The four shift clocks are identical. The two blanking outputs are equal, and the two strobes are equal.
- R7: Blanking is low during every shift-clock pulse and during the strobe, and high in any cycle where the sequencer is idle.
- R8: Suppose a second complete line is already stored in the cycle of a strobe. Then the next cycle begins the following line with blanking low. Otherwise blanking is high in the next cycle.
- R9: A `ln_start` request is accepted only when no line is being filled and fewer than two complete lines are waiting. Otherwise `stall` is high in the next cycle and the request has no effect.
- R10: Lines are emitted in the order they were accepted. The bank released by a strobe can accept a new line from the cycle after that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ln_start | input | 1 | Request to start filling a new line |
| px_valid | input | 1 | Pixel word valid |
| px_rgb | input | 3 | Colour bits of the next column (bit 0, 1, 2 = colour 0, 1, 2) |
| stall | output | 1 | Request refused in the previous cycle |
| grp_sclk | output | 4 | Shift clocks; bits 2g and 2g+1 belong to group g |
| grp_blank | output | 2 | Blanking per driver group |
| grp_stb | output | 2 | Latch strobe per driver group |
| lane_dat | output | MODULES | Serial data lane per driver module |

## Verification
The bench builds the block with 20 columns over 3 modules. This gives module ranges of 7, 7 and 6 columns. The last lane therefore has to emit zero padding on its final three steps, and a whole line shifts out in 21 steps. Because lines are this short, a few thousand cycles cover many bank swaps. Request rates are swept from sparse to saturating. This exercises every path through the states: both banks full with stalls, strobe followed directly by the next line, and idle gaps with blanking raised.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_SETUP,
        RD_CLOCK,
        RD_STROBE
    } rd_state_t;

    typedef enum logic {
        WR_IDLE,
        WR_FILL
    } wr_state_t;

    function automatic int unsigned span_cols(input int unsigned cols, input int unsigned mods);
        return (cols + mods - 1) / mods;
    endfunction

endpackage

// File: rtl/pdl_fill_ctrl.sv
module pdl_fill_ctrl
    import pdl_pkg::*;
#(
    parameter int unsigned MODULES  = 7,
    parameter int unsigned MCOLS    = 122,
    parameter int unsigned LAST_LEN = 121,
    localparam int unsigned MW = $clog2(MODULES),
    localparam int unsigned OW = $clog2(MCOLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ln_start,
    input  logic          px_valid,
    input  logic          rd_release,
    input  logic          rd_bank,
    output logic          wr_en,
    output logic          wr_bank,
    output logic [MW-1:0] wr_mod,
    output logic [OW-1:0] wr_off,
    output logic [1:0]    full_q,
    output logic          stall
);

    localparam logic [MW-1:0] MOD_LAST = MW'(MODULES - 1);
    localparam logic [OW-1:0] OFF_MAX  = OW'(MCOLS - 1);
    localparam logic [OW-1:0] LAST_MAX = OW'(LAST_LEN - 1);

    wr_state_t     state_q, state_d;
    logic          bank_q;
    logic [MW-1:0] mod_q;
    logic [OW-1:0] off_q;
    logic          stall_q;
    logic          free_w, accept_w, mod_end_w, line_end_w;

    assign free_w     = (state_q == WR_IDLE) && !full_q[bank_q];
    assign accept_w   = ln_start && free_w;
    assign mod_end_w  = (mod_q == MOD_LAST) ? (off_q == LAST_MAX) : (off_q == OFF_MAX);
    assign line_end_w = (state_q == WR_FILL) && px_valid && mod_end_w && (mod_q == MOD_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (accept_w)   state_d = WR_FILL;
            WR_FILL: if (line_end_w) state_d = WR_IDLE;
            default: state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q  <= 1'b0;
            mod_q   <= '0;
            off_q   <= '0;
            full_q  <= 2'b00;
            stall_q <= 1'b0;
        end else begin
            stall_q <= ln_start && !free_w;
            if (accept_w) begin
                mod_q <= '0;
                off_q <= '0;
            end else if ((state_q == WR_FILL) && px_valid) begin
                if (mod_end_w) begin
                    off_q <= '0;
                    mod_q <= mod_q + 1'b1;
                end else begin
                    off_q <= off_q + 1'b1;
                end
            end
            if (rd_release) full_q[rd_bank] <= 1'b0;
            if (line_end_w) begin
                full_q[bank_q] <= 1'b1;
                bank_q         <= ~bank_q;
            end
        end
    end

    assign wr_en   = (state_q == WR_FILL) && px_valid;
    assign wr_bank = bank_q;
    assign wr_mod  = mod_q;
    assign wr_off  = off_q;
    assign stall   = stall_q;

    p_release_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_release |-> full_q[rd_bank]);

    p_stall_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q |-> $past(ln_start));

    p_fill_bank_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full_q[wr_bank]);

endmodule

// File: rtl/pdl_lane_store.sv
module pdl_lane_store #(
    parameter int unsigned MCOLS = 122,
    parameter int unsigned LEN   = 122,
    localparam int unsigned OW = $clog2(MCOLS)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [OW-1:0] wr_off,
    input  logic [2:0]    wr_rgb,
    input  logic          rd_bank,
    input  logic [OW-1:0] rd_off,
    input  logic [1:0]    rd_ph,
    output logic          lane_bit
);

    localparam logic [OW:0] LEN_W = (OW + 1)'(LEN);

    logic [2:0] mem_q [2][MCOLS];
    logic [2:0] word_w;

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_bank][wr_off] <= wr_rgb;
    end

    assign word_w = mem_q[rd_bank][rd_off];

    always_comb begin
        if ({1'b0, rd_off} >= LEN_W) begin
            lane_bit = 1'b0;
        end else begin
            unique case (rd_ph)
                2'd0:    lane_bit = word_w[0];
                2'd1:    lane_bit = word_w[1];
                default: lane_bit = word_w[2];
            endcase
        end
    end

endmodule

// File: rtl/pdl_shift_seq.sv
module pdl_shift_seq
    import pdl_pkg::*;
#(
    parameter int unsigned MCOLS = 122,
    localparam int unsigned OW = $clog2(MCOLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    full_q,
    output logic          rd_bank,
    output logic [OW-1:0] rd_off,
    output logic [1:0]    rd_ph,
    output logic          sclk,
    output logic          blank,
    output logic          stb,
    output logic          release_o
);

    localparam logic [OW-1:0] OFF_MAX = OW'(MCOLS - 1);

    rd_state_t     state_q, state_d;
    logic          bank_q;
    logic [OW-1:0] off_q;
    logic [1:0]    ph_q;
    logic          last_bit_w;

    assign last_bit_w = (off_q == OFF_MAX) && (ph_q == 2'd2);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:   if (full_q[bank_q]) state_d = RD_SETUP;
            RD_SETUP:  state_d = RD_CLOCK;
            RD_CLOCK:  state_d = last_bit_w ? RD_STROBE : RD_SETUP;
            RD_STROBE: state_d = full_q[~bank_q] ? RD_SETUP : RD_IDLE;
            default:   state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
            off_q  <= '0;
            ph_q   <= '0;
        end else begin
            unique case (state_q)
                RD_IDLE: begin
                    off_q <= '0;
                    ph_q  <= '0;
                end
                RD_STROBE: begin
                    off_q  <= '0;
                    ph_q   <= '0;
                    bank_q <= ~bank_q;
                end
                RD_CLOCK: begin
                    if (!last_bit_w) begin
                        if (ph_q == 2'd2) begin
                            ph_q  <= '0;
                            off_q <= off_q + 1'b1;
                        end else begin
                            ph_q <= ph_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sclk      = 1'b0;
        blank     = 1'b0;
        stb       = 1'b0;
        release_o = 1'b0;
        unique case (state_q)
            RD_IDLE:   blank = 1'b1;
            RD_SETUP:  ;
            RD_CLOCK:  sclk = 1'b1;
            RD_STROBE: begin
                stb       = 1'b1;
                release_o = 1'b1;
            end
            default:   blank = 1'b1;
        endcase
    end

    assign rd_bank = bank_q;
    assign rd_off  = off_q;
    assign rd_ph   = ph_q;

    p_clock_after_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_CLOCK) |-> ($past(state_q) == RD_SETUP));

    p_strobe_after_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stb |-> ($past(state_q) == RD_CLOCK));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

    p_start_needs_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RD_SETUP) && ($past(state_q) == RD_IDLE)) |-> $past(full_q[bank_q]));

endmodule

// File: rtl/pdl_line_pingpong.sv
module pdl_line_pingpong
    import pdl_pkg::*;
#(
    parameter int unsigned COLS    = 853,
    parameter int unsigned MODULES = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ln_start,
    input  logic               px_valid,
    input  logic [2:0]         px_rgb,
    output logic               stall,
    output logic [3:0]         grp_sclk,
    output logic [1:0]         grp_blank,
    output logic [1:0]         grp_stb,
    output logic [MODULES-1:0] lane_dat
);

    localparam int unsigned MCOLS    = span_cols(COLS, MODULES);
    localparam int unsigned LAST_LEN = COLS - (MODULES - 1) * MCOLS;
    localparam int unsigned MW       = $clog2(MODULES);
    localparam int unsigned OW       = $clog2(MCOLS);

    logic          wr_en, wr_bank;
    logic [MW-1:0] wr_mod;
    logic [OW-1:0] wr_off;
    logic [1:0]    full_q;
    logic          rd_bank, rd_release;
    logic [OW-1:0] rd_off;
    logic [1:0]    rd_ph;
    logic          sclk, blank, stb;

    pdl_fill_ctrl #(
        .MODULES  (MODULES),
        .MCOLS    (MCOLS),
        .LAST_LEN (LAST_LEN)
    ) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .ln_start   (ln_start),
        .px_valid   (px_valid),
        .rd_release (rd_release),
        .rd_bank    (rd_bank),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_mod     (wr_mod),
        .wr_off     (wr_off),
        .full_q     (full_q),
        .stall      (stall)
    );

    pdl_shift_seq #(
        .MCOLS (MCOLS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_q    (full_q),
        .rd_bank   (rd_bank),
        .rd_off    (rd_off),
        .rd_ph     (rd_ph),
        .sclk      (sclk),
        .blank     (blank),
        .stb       (stb),
        .release_o (rd_release)
    );

    for (genvar k = 0; k < MODULES; k++) begin : g_lane
        localparam int unsigned   LEN = (k == MODULES - 1) ? LAST_LEN : MCOLS;
        localparam logic [MW-1:0] KID = MW'(k);
        logic sel_w;
        assign sel_w = wr_en && (wr_mod == KID);
        pdl_lane_store #(
            .MCOLS (MCOLS),
            .LEN   (LEN)
        ) u_store (
            .clk      (clk),
            .wr_en    (sel_w),
            .wr_bank  (wr_bank),
            .wr_off   (wr_off),
            .wr_rgb   (px_rgb),
            .rd_bank  (rd_bank),
            .rd_off   (rd_off),
            .rd_ph    (rd_ph),
            .lane_bit (lane_dat[k])
        );
    end

    assign grp_sclk  = {4{sclk}};
    assign grp_blank = {2{blank}};
    assign grp_stb   = {2{stb}};

endmodule

// File: tb/pdl_line_pingpong_tb.sv
`timescale 1ns/1ps
module pdl_line_pingpong_tb;

    localparam int COLS    = 20;
    localparam int MODULES = 3;
    localparam int MC      = (COLS + MODULES - 1) / MODULES;
    localparam int STEPS   = 3 * MC;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ln_start = 1'b0;
    logic               px_valid = 1'b0;
    logic [2:0]         px_rgb = 3'd0;
    logic               stall;
    logic [3:0]         grp_sclk;
    logic [1:0]         grp_blank;
    logic [1:0]         grp_stb;
    logic [MODULES-1:0] lane_dat;

    int total = 0;
    int bad   = 0;
    logic [2:0] ring [4][COLS];

    always #2.5 clk = ~clk;

    pdl_line_pingpong #(.COLS(COLS), .MODULES(MODULES)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ln_start  (ln_start),
        .px_valid  (px_valid),
        .px_rgb    (px_rgb),
        .stall     (stall),
        .grp_sclk  (grp_sclk),
        .grp_blank (grp_blank),
        .grp_stb   (grp_stb),
        .lane_dat  (lane_dat)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input int lane, input int step, input int slot);
        int col;
        col = lane * MC + step / 3;
        if (col >= COLS) return 1'b0;
        return ring[slot][col][step % 3];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int   pending, wr_line, rd_line, wr_idx, cap_step, line_bad, rate;
        logic writing, drv_px, drv_start, acc_pred, prev_stb, prev_sclk;
        logic exp_blank_valid, exp_blank;
        logic [2:0] drv_rgb;
        void'($urandom(32'h5eed_1234));
        pending = 0; wr_line = 0; rd_line = 0; wr_idx = 0; cap_step = 0; line_bad = 0;
        writing = 0; drv_px = 0; drv_start = 0; acc_pred = 0; drv_rgb = 0;
        prev_stb = 0; prev_sclk = 0; exp_blank_valid = 0; exp_blank = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(grp_blank == 2'b11, "R1 blank", grp_blank, 3);
        chk(grp_sclk == 4'b0000, "R1 sclk", grp_sclk, 0);
        chk(grp_stb == 2'b00, "R1 stb", grp_stb, 0);
        chk(stall == 1'b0, "R1 stall", stall, 0);
        rst_n = 1'b1;

        for (int cyc = 0; cyc < 7000; cyc++) begin
            logic [3:0] s_sclk;
            logic [1:0] s_blank, s_stb;
            logic       s_stall;
            @(negedge clk);
            s_sclk = grp_sclk; s_blank = grp_blank; s_stb = grp_stb; s_stall = stall;

            // model the edge just passed (R3: pixels only stored while filling)
            if (drv_px && writing) begin
                ring[wr_line % 4][wr_idx] = drv_rgb;
                wr_idx++;
                if (wr_idx == COLS) begin
                    writing = 0;
                    pending++;
                    wr_line++;
                end
            end
            if (drv_start && acc_pred) begin
                writing = 1;
                wr_idx  = 0;
            end
            // R9: stall on refused request only
            if ((drv_start && !acc_pred) || s_stall)
                chk(s_stall == (drv_start && !acc_pred), "R9 stall", s_stall, drv_start && !acc_pred);
            if (prev_stb) pending--;

            // R6: groups identical
            chk((s_sclk == 4'b0000 || s_sclk == 4'b1111) && (s_blank[0] == s_blank[1]) &&
                (s_stb[0] == s_stb[1]), "R6 groups", {s_sclk, s_blank, s_stb}, 0);
            // R7: blank low while shifting or strobing
            if (s_sclk[0] || s_stb[0])
                chk(!s_blank[0], "R7 blank", s_blank[0], 0);
            // R8: continuity after a strobe
            if (exp_blank_valid) begin
                chk(s_blank[0] == exp_blank, "R8 follow", s_blank[0], exp_blank);
                exp_blank_valid = 0;
            end
            // R4: one-cycle clock pulses
            if (s_sclk[0] && prev_sclk)
                chk(1'b0, "R4 pulse", 2, 1);
            // R2: lane capture
            if (s_sclk[0]) begin
                for (int k = 0; k < MODULES; k++)
                    if (lane_dat[k] !== exp_bit(k, cap_step, rd_line % 4)) line_bad++;
                cap_step++;
            end
            if (s_stb[0]) begin
                chk(!prev_stb, "R5 single", 1, 0);
                chk(prev_sclk, "R5 after last clock", prev_sclk, 1);
                chk(cap_step == STEPS, "R4 count", cap_step, STEPS);
                chk(rd_line < wr_line, "R10 order", rd_line, wr_line);
                chk(line_bad == 0, "R2 lane data", line_bad, 0);
                exp_blank_valid = 1;
                exp_blank = (pending < 2);
                rd_line++;
                cap_step = 0;
                line_bad = 0;
            end
            prev_stb  = s_stb[0];
            prev_sclk = s_sclk[0];

            // drive for next edge
            rate = (cyc < 3000) ? 30 : (cyc < 6000) ? 3 : 100;
            drv_px    = writing ? (($urandom % 4) != 0) : (($urandom % 8) == 0);
            drv_rgb   = 3'($urandom % 8);
            drv_start = (cyc < 2) ? 1'b1 : (int'($urandom % 100) < rate);
            acc_pred  = drv_start && !writing && (pending < 2);
            ln_start  = drv_start;
            px_valid  = drv_px;
            px_rgb    = drv_rgb;
        end
        ln_start = 0;
        px_valid = 0;
        // R10: enough lines moved through both banks
        chk(rd_line >= 40, "R10 throughput", rd_line, 40);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule